// File: doc/BRIEF.md
# Console Character Output Port

This block is a character output peripheral on a 16-bit word bus. It answers at two fixed word addresses. A status word carries a single readiness flag in its sign bit. A data word takes a character in its low byte. Software loads the status word and loops with a branch-if-non-negative until the flag is set, then stores the character to the data word.

The port then offers the byte to a downstream sink over a valid/ready byte stream. It holds the readiness flag low until the sink takes the byte. A store made while the port is busy is dropped, so the byte already in flight is never overwritten. Bus reads are combinational and return zero when the read enable is low.

Top module: `console_out_port`

## Requirements
- R1: After reset the status word reads 0x8000, the data word reads 0x0000 and `outValid` is low.
- R2: A read of the status address (0xF3FC) returns the readiness flag in bit 15. Bits 14:0 always read zero.
- R3: A write to the data address (0xF3FF) while ready latches `busWrData[7:0]`. From the next cycle `outByte` shows that byte, `outValid` is high and status bit 15 reads 0.
- R4: While `outValid` is high and `outReady` is low, `outValid` stays high and `outByte` holds its value.
- R5: A cycle with both `outValid` and `outReady` high completes the transfer. From the next cycle `outValid` is low and status bit 15 reads 1. Every accepted write produces exactly one transfer.
- R6: A write to the data address while not ready is ignored: `outByte`, the data readback and the transfer count are unchanged.
- R7: Writes to the status address have no effect on readiness or on the stored character.
- R8: A read of the data address returns the last accepted character in bits 7:0, with bits 15:8 equal to zero.
- R9: Reads of any other address return zero. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Word address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data (combinational) |
| outValid | output | 1 | Byte offered to sink |
| outByte | output | 8 | Byte to sink |
| outReady | input | 1 | Sink accepts byte |

## Verification
The bench builds the port with its default parameters: a 16-bit word, an 8-bit character, status at 0xF3FC and data at 0xF3FF. These defaults make the sign-bit polling loop, the zero extension of the stored character in bits 15:8, and the dropping of upper write bits all observable. A back-pressured sink exercises hold and drop behaviour. A sink that is always ready exercises the fastest poll/write/accept round trip.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef struct packed {
    logic loadChar;
    logic rearm;
  } consStrobe_t;

  typedef enum logic [1:0] {SEL_NONE, SEL_STATUS, SEL_DATA} rdSel_t;
endpackage

// File: rtl/console_ctrl.sv
module console_ctrl
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hF3FC,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hF3FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              outReady,
  output consStrobe_t       strobe,
  output rdSel_t            rdSel,
  output logic              readyFlag
);
  logic hitData, hitStatus;

  assign hitData   = (busAddr == DATA_ADDR);
  assign hitStatus = (busAddr == STATUS_ADDR);

  always_comb begin
    strobe.loadChar = busWrEn && hitData && readyFlag;
    strobe.rearm    = !readyFlag && outReady;
  end

  always_comb begin
    if (!busRdEn)       rdSel = SEL_NONE;
    else if (hitStatus) rdSel = SEL_STATUS;
    else if (hitData)   rdSel = SEL_DATA;
    else                rdSel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                readyFlag <= 1'b1;
    else if (strobe.loadChar) readyFlag <= 1'b0;
    else if (strobe.rearm)    readyFlag <= 1'b1;
  end
endmodule

// File: rtl/console_dp.sv
module console_dp
  import console_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int READY_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  consStrobe_t       strobe,
  input  rdSel_t            rdSel,
  input  logic              readyFlag,
  input  logic [CHAR_W-1:0] wrChar,
  output logic [DATA_W-1:0] rdData,
  output logic [CHAR_W-1:0] charOut
);
  localparam int PAD_W = DATA_W - CHAR_W;

  logic [CHAR_W-1:0] charReg;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                charReg <= '0;
    else if (strobe.loadChar) charReg <= wrChar;
  end

  always_comb begin
    statusWord            = '0;
    statusWord[READY_BIT] = readyFlag;
  end

  always_comb begin
    unique case (rdSel)
      SEL_STATUS: rdData = statusWord;
      SEL_DATA:   rdData = {{PAD_W{1'b0}}, charReg};
      default:    rdData = '0;
    endcase
  end

  assign charOut = charReg;
endmodule

// File: rtl/console_out_port.sv
module console_out_port
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hF3FC,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hF3FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              outValid,
  output logic [CHAR_W-1:0] outByte,
  input  logic              outReady
);
  consStrobe_t strobe;
  rdSel_t      rdSel;
  logic        readyFlag;

  console_ctrl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .outReady(outReady), .strobe(strobe), .rdSel(rdSel), .readyFlag(readyFlag)
  );

  console_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .readyFlag(readyFlag),
    .wrChar(busWrData[CHAR_W-1:0]), .rdData(busRdData), .charOut(outByte)
  );

  assign outValid = !readyFlag;
endmodule

// File: rtl/console_out_port_chk.sv
module console_out_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hF3FC,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hF3FF
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              outValid,
  input logic [CHAR_W-1:0] outByte,
  input logic              outReady
);
  localparam logic [DATA_W-1:0] CHAR_MASK = DATA_W'((1 << CHAR_W) - 1);

  logic wrData, rdStat, rdOther;
  assign wrData  = busWrEn && busAddr == DATA_ADDR;
  assign rdStat  = busRdEn && busAddr == STATUS_ADDR;
  assign rdOther = busRdEn && busAddr != STATUS_ADDR && busAddr != DATA_ADDR;

  // R2: status word carries only the readiness flag
  p_status_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdStat |-> (busRdData == {!outValid, {(DATA_W-1){1'b0}}}));

  // R3: accepted write is offered next cycle with its low byte
  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && !outValid) |=> (outValid &&
      DATA_W'(outByte) == ($past(busWrData) & CHAR_MASK)));

  // R4: hold under back-pressure
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));

  // R5: handshake releases the port
  p_rearm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> !outValid);

  // R6: busy write leaves the byte alone
  p_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && outValid) |=> $stable(outByte));

  // R9: unmapped reads return zero
  p_other_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdOther |-> (busRdData == '0));
endmodule

bind console_out_port console_out_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
  .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busWrData(busWrData), .busRdData(busRdData), .outValid(outValid),
  .outByte(outByte), .outReady(outReady)
);

// File: tb/console_out_port_tb.sv
module console_out_port_tb;
  localparam logic [15:0] ST_A = 16'hF3FC;
  localparam logic [15:0] DT_A = 16'hF3FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic outValid;
  logic [7:0] outByte;
  logic outReady = 1'b0;

  int nTests = 0, nFail = 0, nPopped = 0;
  logic [7:0] expQ[$];
  logic done = 1'b0;

  always #4 clk = ~clk;

  console_out_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .outValid(outValid),
    .outByte(outByte), .outReady(outReady)
  );

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected byte on each handshake
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) check(1'b0, "R5 extra transfer", {8'h0, outByte}, 16'h0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        nPopped++;
        check(outByte == e, "R3 transfer byte", {8'h0, outByte}, {8'h0, e});
      end
    end
  end

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d, input logic pushExp);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    if (pushExp) expQ.push_back(d[7:0]);
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [15:0] d);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic pollWrite(input logic [15:0] d);
    logic [15:0] s;
    do begin
      @(posedge clk); #1;
      busRead(ST_A, s);
    end while (!s[15]);
    busWrite(DT_A, d, 1'b1);
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 16'h0, 16'h0);
    done = 1'b1;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid after reset", {15'h0, outValid}, 16'h0);
    busRead(ST_A, rd); check(rd == 16'h8000, "R1 status after reset", rd, 16'h8000);
    busRead(DT_A, rd); check(rd == 16'h0000, "R1 data after reset", rd, 16'h0000);

    // R3: accepted write, sink stalled
    busWrite(DT_A, 16'h1241, 1'b1);
    @(negedge clk);
    check(outValid == 1'b1, "R3 valid after write", {15'h0, outValid}, 16'h1);
    check(outByte == 8'h41, "R3 byte", {8'h0, outByte}, 16'h0041);
    busRead(ST_A, rd); check(rd == 16'h0000, "R2 busy status", rd, 16'h0000);

    // R4: hold
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid && outByte == 8'h41, "R4 hold", {7'h0, outValid, outByte}, 16'h0141);
    end

    // R6: busy write dropped
    busWrite(DT_A, 16'h55AA, 1'b0);
    @(negedge clk);
    check(outByte == 8'h41, "R6 byte unchanged", {8'h0, outByte}, 16'h0041);
    busRead(DT_A, rd); check(rd == 16'h0041, "R8 R6 data readback", rd, 16'h0041);

    // R7: status write no effect
    busWrite(ST_A, 16'hFFFF, 1'b0);
    @(negedge clk);
    busRead(ST_A, rd); check(rd == 16'h0000, "R7 status unchanged", rd, 16'h0000);
    check(outByte == 8'h41, "R7 byte unchanged", {8'h0, outByte}, 16'h0041);

    // R5: single-cycle accept
    @(posedge clk); #1 outReady = 1'b1;
    @(posedge clk); #1 outReady = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R5 valid cleared", {15'h0, outValid}, 16'h0);
    busRead(ST_A, rd); check(rd == 16'h8000, "R5 ready again", rd, 16'h8000);

    // R9: unmapped address
    busWrite(16'h1234, 16'h00EE, 1'b0);
    @(negedge clk);
    check(outValid == 1'b0, "R9 no transfer", {15'h0, outValid}, 16'h0);
    busRead(16'h1234, rd); check(rd == 16'h0000, "R9 read zero", rd, 16'h0000);
    busRead(DT_A, rd); check(rd == 16'h0041, "R9 data unchanged", rd, 16'h0041);

    // streaming with always-ready sink
    outReady = 1'b1;
    pollWrite(16'hAB30);
    pollWrite(16'h0031);
    pollWrite(16'hFF7E);
    repeat (4) @(posedge clk);
    @(negedge clk);
    busRead(DT_A, rd); check(rd == 16'h007E, "R8 zero-extended readback", rd, 16'h007E);
    check(expQ.size() == 0, "R5 queue drained", 16'(expQ.size()), 16'h0);
    check(nPopped == 4, "R5 transfer count", 16'(nPopped), 16'd4);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule